// File: doc/BRIEF.md
# Countdown Timer Channel with One-Shot and Periodic Modes

This block is a single timer channel. Software programs it through a small strobe-based register port. It counts down a value of up to 29 bits, advancing only on cycles where a tick enable is high, nominally once per microsecond. When the count expires, the block raises a level interrupt. The interrupt stays high until software clears it by writing a one to the clear bit of the status register.

Counting uses an n+1 scheme: a programmed value N expires on the (N+1)-th tick, so a value of 0 fires on the very next tick. In periodic mode the counter reloads the programmed value on every expiry and keeps running. In one-shot mode the counter stops at zero and the run bit drops by itself.

The channel has two registers:

| Offset | Name | Fields |
|---|---|---|
| 0x0 | Control | bit 31 = run, bit 30 = periodic select, bits 28:0 = load value |
| 0x4 | Status | bits 28:0 = live count, bit 30 = pending interrupt |

Writing a one to bit 30 of the status register clears the pending flag.

Top module: `cdt_channel`

## Requirements
- R1: After reset, `irq` is 0 and both registers read 0.
- R2: In the control register, bit 31 is run, bit 30 selects periodic mode and bits 28:0 are the load value. Reading the register returns these fields as written, and bit 29 always reads 0.
- R3: A load value N written with run set causes `irq` to rise after exactly N+1 tick cycles. A load value of 0 fires after one tick.
- R4: In periodic mode, the count reloads to N on expiry and the channel keeps running, so `irq` is set again every N+1 ticks. The run bit stays 1.
- R5: In one-shot mode, the run bit reads 0 after expiry. The count then stays at 0 and raises no further interrupt.
- R6: Writing 0 to the control register stops the channel, and no interrupt follows.
- R7: Writing the status register with bit 30 set clears the pending flag. A status write with bit 30 clear leaves the flag unchanged.
- R8: Reading the status register returns the live count in bits 28:0 and the pending flag in bit 30. All other bits read 0.
- R9: A control write while the channel is running restarts the count from the new load value at once.
- R10: When an expiry and a clear fall in the same cycle, the expiry wins and the interrupt stays pending.
- R11: The count changes only in cycles with `tick_en` high.
- R12: A control write in a tick cycle takes priority over that tick, so the count starts from the new value with no decrement in that cycle.
- R13: The full 29-bit load value 0x1FFFFFFF is accepted and counts down normally.
- R14: `rd_data` is updated one cycle after an `rd_en` strobe and holds between strobes. A read of any other address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset. It asserts asynchronously and is released synchronously to `clk`. |
| tick_en | input | 1 | Count-advance enable, one cycle high per microsecond |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Write byte address: 0x0 = control, 0x4 = status |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | 32 | Registered read data |
| irq | output | 1 | Level interrupt: high while the pending flag is set |

## Verification
A register write applied before a clock edge takes effect at that edge. A tick applied at an edge changes the count at that edge, and an expiry drives `irq` high straight from the flag set at that same edge. The bench therefore samples `irq` at the falling edge after the last tick of each window. Read data is due one edge after the `rd_en` strobe. The driver queues the expected word when it raises the strobe, and the monitor pops and compares that word at the falling edge that follows the capturing edge. Ticks are held low during reads, so each expected count is fixed by the exact number of tick cycles the bench has issued.

// File: rtl/cdt_pkg.sv
package cdt_pkg;
  localparam int DATA_W   = 32;
  localparam int RUN_BIT  = 31;
  localparam int PER_BIT  = 30;
  localparam int PEND_BIT = 30;
  localparam int CTRL_OFF = 0;
  localparam int STAT_OFF = 4;
endpackage

// File: rtl/cdt_counter.sv
module cdt_counter #(
  parameter int CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_en,
  input  logic             load_wr,
  input  logic             load_run,
  input  logic             load_per,
  input  logic [CNT_W-1:0] load_val,
  output logic             run_o,
  output logic             per_o,
  output logic [CNT_W-1:0] load_o,
  output logic [CNT_W-1:0] count_o,
  output logic             expire_o
);
  logic             run_q, run_d, per_q, per_d;
  logic [CNT_W-1:0] load_q, load_d, cnt_q, cnt_d;
  logic             at_zero;

  assign at_zero  = (cnt_q == '0);
  assign expire_o = run_q & tick_en & ~load_wr & at_zero;

  always_comb begin
    run_d  = run_q;
    per_d  = per_q;
    load_d = load_q;
    cnt_d  = cnt_q;
    if (load_wr) begin
      run_d  = load_run;
      per_d  = load_per;
      load_d = load_val;
      cnt_d  = load_val;
    end else if (run_q && tick_en) begin
      if (at_zero) begin
        if (per_q) cnt_d = load_q;
        else       run_d = 1'b0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      per_q  <= 1'b0;
      load_q <= '0;
      cnt_q  <= '0;
    end else begin
      run_q  <= run_d;
      per_q  <= per_d;
      load_q <= load_d;
      cnt_q  <= cnt_d;
    end
  end

  assign run_o   = run_q;
  assign per_o   = per_q;
  assign load_o  = load_q;
  assign count_o = cnt_q;

  AST_ONESHOT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && !per_q) |=> !run_q); // R5
  AST_PERIODIC_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_o && per_q) |=> (run_q && cnt_q == $past(load_q))); // R4
  AST_TICK_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && tick_en && !load_wr && !at_zero) |=> (cnt_q == $past(cnt_q) - 1'b1)); // R3
  AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !load_wr) |=> $stable(cnt_q)); // R11
  AST_WRITE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (cnt_q == $past(load_val) && run_q == $past(load_run))); // R9
endmodule

// File: rtl/cdt_irq.sv
module cdt_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic expire,
  input  logic clr,
  output logic pend_o
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (clr)    pend_d = 1'b0;
    if (expire) pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pend_o = pend_q;

  AST_EXPIRE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> pend_q); // R10
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !expire) |=> !pend_q); // R7
endmodule

// File: rtl/cdt_channel.sv
module cdt_channel #(
  parameter int ADDR_W = 4,
  parameter int CNT_W  = 29
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_en,
  input  logic                      wr_en,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [cdt_pkg::DATA_W-1:0] wr_data,
  input  logic                      rd_en,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [cdt_pkg::DATA_W-1:0] rd_data,
  output logic                      irq
);
  import cdt_pkg::*;

  logic             wr_ctrl, wr_stat, clr;
  logic             run, per, expire, pend;
  logic [CNT_W-1:0] load, count;
  logic [DATA_W-1:0] rd_d, rd_q;
  logic             unused_bits;

  assign wr_ctrl     = wr_en && (wr_addr == ADDR_W'(CTRL_OFF));
  assign wr_stat     = wr_en && (wr_addr == ADDR_W'(STAT_OFF));
  assign clr         = wr_stat && wr_data[PEND_BIT];
  assign unused_bits = ^wr_data;

  cdt_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_en  (tick_en),
    .load_wr  (wr_ctrl),
    .load_run (wr_data[RUN_BIT]),
    .load_per (wr_data[PER_BIT]),
    .load_val (wr_data[CNT_W-1:0]),
    .run_o    (run),
    .per_o    (per),
    .load_o   (load),
    .count_o  (count),
    .expire_o (expire)
  );

  cdt_irq u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .expire (expire),
    .clr    (clr),
    .pend_o (pend)
  );

  always_comb begin
    rd_d = '0;
    if (rd_addr == ADDR_W'(CTRL_OFF)) begin
      rd_d[CNT_W-1:0] = load;
      rd_d[PER_BIT]   = per;
      rd_d[RUN_BIT]   = run;
    end else if (rd_addr == ADDR_W'(STAT_OFF)) begin
      rd_d[CNT_W-1:0] = count;
      rd_d[PEND_BIT]  = pend;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_d;
  end

  assign rd_data = rd_q;
  assign irq     = pend;

  AST_READ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data)); // R14
  AST_ZERO_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && wr_data == '0) |=> (!run && !expire)); // R6
endmodule

// File: tb/cdt_channel_test.sv
`timescale 1ns/1ps
module cdt_channel_test;
  localparam int ADDR_W = 4;
  localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_BAD = 4'h8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick_en = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [ADDR_W-1:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic irq;

  int vectors = 0, miscompares = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        mon_v = 1'b0;
  bit          done = 1'b0;

  always #4 clk = ~clk;

  cdt_channel #(.ADDR_W(ADDR_W), .CNT_W(29)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
  );

  always @(posedge clk) mon_v <= rd_en;

  always @(negedge clk) begin
    if (mon_v && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (rd_data !== e) begin
        miscompares++;
        $display("FAIL %s: rd_data actual %h expected %h", t, rd_data, e);
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] e, input string t);
    rd_en = 1'b1; rd_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    tick_en = 1'b1;
    repeat (n) @(negedge clk);
    tick_en = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    vectors++;
    if (irq !== e) begin
      miscompares++;
      $display("FAIL %s: irq actual %b expected %b", t, irq, e);
    end
  endtask

  task automatic clear_irq();
    wr(A_STAT, 32'h4000_0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_irq(1'b0, "R1");
    rd(A_CTRL, 32'h0, "R1");
    rd(A_STAT, 32'h0, "R1");

    // R3 n+1 one-shot, load 3
    wr(A_CTRL, 32'h8000_0003);
    rd(A_CTRL, 32'h8000_0003, "R2");
    ticks(3);
    chk_irq(1'b0, "R3");
    rd(A_STAT, 32'h0000_0000, "R8");
    ticks(1);
    chk_irq(1'b1, "R3");
    rd(A_CTRL, 32'h0000_0003, "R5");
    rd(A_STAT, 32'h4000_0000, "R8");
    // R7 status write without bit 30 keeps pending
    wr(A_STAT, 32'hBFFF_FFFF);
    chk_irq(1'b1, "R7");
    clear_irq();
    chk_irq(1'b0, "R7");
    // R5 one-shot stays idle
    ticks(6);
    chk_irq(1'b0, "R5");
    rd(A_STAT, 32'h0, "R5");

    // R3 load 0 fires after one tick
    wr(A_CTRL, 32'h8000_0000);
    chk_irq(1'b0, "R3");
    ticks(1);
    chk_irq(1'b1, "R3");
    clear_irq();

    // R4 periodic, load 2
    wr(A_CTRL, 32'hC000_0002);
    ticks(3);
    chk_irq(1'b1, "R4");
    rd(A_STAT, 32'h4000_0002, "R4");
    clear_irq();
    ticks(2);
    chk_irq(1'b0, "R4");
    ticks(1);
    chk_irq(1'b1, "R4");
    rd(A_CTRL, 32'hC000_0002, "R4");
    ticks(1);
    rd(A_STAT, 32'h4000_0001, "R4");

    // R6 stop with zero write
    wr(A_CTRL, 32'h0);
    clear_irq();
    rd(A_CTRL, 32'h0, "R6");
    ticks(10);
    chk_irq(1'b0, "R6");
    rd(A_STAT, 32'h0, "R6");

    // R9 restart while running
    wr(A_CTRL, 32'h8000_0005);
    ticks(2);
    rd(A_STAT, 32'h0000_0003, "R9");
    wr(A_CTRL, 32'h8000_0001);
    rd(A_STAT, 32'h0000_0001, "R9");
    ticks(1);
    chk_irq(1'b0, "R9");
    ticks(1);
    chk_irq(1'b1, "R9");
    clear_irq();

    // R10 expiry and clear in the same cycle
    wr(A_CTRL, 32'h8000_0000);
    tick_en = 1'b1; wr_en = 1'b1; wr_addr = A_STAT; wr_data = 32'h4000_0000;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    chk_irq(1'b1, "R10");
    clear_irq();

    // R11 no ticks, no movement
    wr(A_CTRL, 32'h8000_0004);
    repeat (20) @(negedge clk);
    rd(A_STAT, 32'h0000_0004, "R11");

    // R12 control write in a tick cycle
    tick_en = 1'b1; wr_en = 1'b1; wr_addr = A_CTRL; wr_data = 32'h8000_0007;
    @(negedge clk);
    tick_en = 1'b0; wr_en = 1'b0;
    rd(A_STAT, 32'h0000_0007, "R12");

    // R13 full range and R2 bit 29 reads zero
    wr(A_CTRL, 32'h9FFF_FFFF);
    rd(A_CTRL, 32'h9FFF_FFFF, "R13");
    rd(A_STAT, 32'h1FFF_FFFF, "R13");
    ticks(2);
    rd(A_STAT, 32'h1FFF_FFFD, "R13");
    wr(A_CTRL, 32'h7FFF_FFFF);
    rd(A_CTRL, 32'h5FFF_FFFF, "R2");

    // R14 unmapped address and hold between strobes
    rd(A_BAD, 32'h0, "R14");
    repeat (3) @(negedge clk);
    vectors++;
    if (rd_data !== 32'h0) begin
      miscompares++;
      $display("FAIL R14: held rd_data actual %h expected %h", rd_data, 32'h0);
    end

    repeat (3) @(negedge clk);
    vectors++;
    if (exp_q.size() != 0) begin
      miscompares++;
      $display("FAIL R14: reads outstanding actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule